// File: doc/BRIEF.md
# Per-Thread Squash and Trap Controller

This block keeps one pipeline-recovery state for every hardware thread of a multithreaded out-of-order core. The states are idle, running, squashing (waiting for the reorder buffer to drain the squashed instructions), trap-wait and fetch-fault-wait. It takes squash requests from the execute stage, trap and context-squash requests, fetch-fault pulses and a done-squashing report from the reorder buffer. From these it issues one registered squash command per thread: a one-cycle pulse carrying the boundary sequence number and the redirect PC.

Each thread records the youngest sequence number that has entered the buffer. A squash from the execute stage is accepted only if it is no younger than that record. This keeps a late squash from a younger instruction from overriding an earlier squash from an older one. A trap request starts a programmable countdown, and the thread-wide squash fires when the countdown ends. A context squash also flushes the whole thread. When every thread is squashing, the block raises a global stall so that insertion and commit stop for that cycle.

Top module: `thread_squash_ctrl`

## Requirements
- R1: An execute-stage squash is accepted only if its sequence number is less than or equal to the thread's recorded youngest sequence number and the thread is not in trap-wait. A rejected squash produces no command and does not change `sq_rob_o`.
- R2: When `ex_incl_i` is set, the boundary is the squash sequence number minus one. Otherwise the boundary is the squash sequence number unchanged.
- R3: An accepted squash sets the thread's `sq_rob_o` bit and raises `squash_cnt_o` by one, on the edge after the request. On that same edge it sends one `sq_valid_o` pulse carrying the boundary and `ex_pc_i`. The boundary also becomes the thread's youngest sequence number.
- R4: A squashing thread returns to running on the edge at which `rob_done_i` is high for it. Its `sq_rob_o` bit clears and `squash_cnt_o` drops by one.
- R5: A trap request puts the thread in trap-wait and loads the countdown from `trap_lat_i`. The thread-wide squash pulse appears on the edge L+1 cycles after the request edge, where L is the loaded latency. Execute squashes are ignored during trap-wait.
- R6: A context squash that arrives while a trap countdown is running is held. It is served on the cycle after the trap squash, so the trap squash always comes first.
- R7: A trap or context squash uses the boundary `rob_head_seq_i` minus one, or zero if `rob_empty_i` is set. It uses `restart_pc_i` as the redirect PC and resets the youngest sequence number to zero.
- R8: A fetch fault sets `fault_pend_o` for the thread unless the thread is in trap-wait. A clear pulse returns a fault-waiting thread to running and drops `fault_pend_o`.
- R9: `stall_o` is high exactly when every thread is squashing. While it is high, insertions are not recorded.
- R10: After reset all outputs are zero and every thread is idle with a youngest sequence number of zero. An insertion records `ins_seq_i` as the youngest sequence number and moves an idle thread to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_lat_i | input | LAT_W | Trap countdown load value |
| ex_squash_i | input | NUM_THREADS | Execute-stage squash request per thread |
| ex_seq_i | input | NUM_THREADS x SEQ_W | Squash sequence number per thread |
| ex_incl_i | input | NUM_THREADS | Include the squashing instruction itself |
| ex_pc_i | input | NUM_THREADS x PC_W | Redirect PC for an execute squash |
| ins_valid_i | input | NUM_THREADS | Instruction inserted into the buffer |
| ins_seq_i | input | NUM_THREADS x SEQ_W | Sequence number of the inserted instruction |
| fetch_fault_i | input | NUM_THREADS | Fetch fault pulse |
| fetch_clear_i | input | NUM_THREADS | Clear fetch fault pulse |
| trap_req_i | input | NUM_THREADS | Trap request pulse |
| ctx_squash_i | input | NUM_THREADS | Context squash request pulse |
| rob_done_i | input | NUM_THREADS | Reorder buffer finished squashing |
| rob_empty_i | input | NUM_THREADS | Reorder buffer holds nothing for the thread |
| rob_head_seq_i | input | NUM_THREADS x SEQ_W | Sequence number at the buffer head |
| restart_pc_i | input | NUM_THREADS x PC_W | Redirect PC for a thread-wide squash |
| sq_valid_o | output | NUM_THREADS | Squash command pulse |
| sq_seq_o | output | NUM_THREADS x SEQ_W | Squash boundary sequence number |
| sq_pc_o | output | NUM_THREADS x PC_W | Squash redirect PC |
| sq_rob_o | output | NUM_THREADS | Thread is squashing |
| fault_pend_o | output | NUM_THREADS | Thread waits on a fetch fault |
| squash_cnt_o | output | $clog2(NUM_THREADS+1) | Number of squashing threads |
| stall_o | output | 1 | All threads squashing |

## Verification
The bench builds the block with two threads, 16-bit sequence numbers and an 8-bit countdown. With two threads, a single pair of simultaneous execute squashes is enough to reach the all-squashing stall and to show that insertions are dropped during it. The latency input is set to 3, 2 and 0 at different points. This places the trap pulse at a known edge, and with a latency of 2 there is time to send a context squash and a fetch fault into the countdown window before the trap fires.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [2:0] {
    TS_IDLE  = 3'd0,
    TS_RUN   = 3'd1,
    TS_SQ    = 3'd2,
    TS_TRAP  = 3'd3,
    TS_FTRAP = 3'd4
  } tstate_e;
endpackage

// File: rtl/tsq_trap_timer.sv
module tsq_trap_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             busy_o,
  output logic             fire_o
);
  logic             pend_q;
  logic [LAT_W-1:0] cnt_q;

  assign busy_o = pend_q;
  assign fire_o = pend_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      pend_q <= 1'b1;
      cnt_q  <= lat_i;
    end else if (fire_o) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      cnt_q <= cnt_q - LAT_W'(1);
    end
  end
endmodule

// File: rtl/tsq_thread.sv
module tsq_thread
  import tsq_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             ex_vld_i,
  input  logic [SEQ_W-1:0] ex_seq_i,
  input  logic             ex_incl_i,
  input  logic [PC_W-1:0]  ex_pc_i,
  input  logic             ins_vld_i,
  input  logic [SEQ_W-1:0] ins_seq_i,
  input  logic             fault_i,
  input  logic             clear_i,
  input  logic             trap_req_i,
  input  logic             ctx_req_i,
  input  logic             rob_done_i,
  input  logic             rob_empty_i,
  input  logic [SEQ_W-1:0] head_seq_i,
  input  logic [PC_W-1:0]  restart_pc_i,
  output tstate_e          state_o,
  output logic             trap_wait_o,
  output logic             sq_vld_o,
  output logic [SEQ_W-1:0] sq_seq_o,
  output logic [PC_W-1:0]  sq_pc_o
);
  tstate_e          st_q, st_n;
  logic [SEQ_W-1:0] young_q, young_n, ex_bnd;
  logic             ctx_q, ctx_n, ctx_go;
  logic             vld_q, vld_n;
  logic [SEQ_W-1:0] seq_q, seq_n;
  logic [PC_W-1:0]  pc_q, pc_n;
  logic             tmr_busy, tmr_fire;

  tsq_trap_timer #(.LAT_W(LAT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(trap_req_i),
    .lat_i (lat_i),
    .busy_o(tmr_busy),
    .fire_o(tmr_fire)
  );

  assign ex_bnd = ex_incl_i ? ex_seq_i - SEQ_W'(1) : ex_seq_i;
  // context squash waits behind a running or starting trap countdown
  assign ctx_go = (ctx_q || ctx_req_i) && !tmr_busy && !trap_req_i;

  always_comb begin
    st_n    = st_q;
    young_n = young_q;
    ctx_n   = ctx_q || ctx_req_i;
    vld_n   = 1'b0;
    seq_n   = '0;
    pc_n    = '0;

    if (ins_vld_i && !stall_i) begin
      young_n = ins_seq_i;
      if (st_n == TS_IDLE) st_n = TS_RUN;
    end
    if (st_q == TS_SQ && rob_done_i) st_n = TS_RUN;
    if (fault_i && st_n != TS_TRAP) st_n = TS_FTRAP;
    if (clear_i && st_n == TS_FTRAP) st_n = TS_RUN;
    if (trap_req_i) st_n = TS_TRAP;

    if (tmr_fire || ctx_go) begin
      st_n    = TS_SQ;
      young_n = '0;
      vld_n   = 1'b1;
      seq_n   = rob_empty_i ? '0 : head_seq_i - SEQ_W'(1);
      pc_n    = restart_pc_i;
      if (!tmr_fire) ctx_n = 1'b0;
    end

    if (ex_vld_i && st_n != TS_TRAP && ex_seq_i <= young_n) begin
      st_n    = TS_SQ;
      young_n = ex_bnd;
      vld_n   = 1'b1;
      seq_n   = ex_bnd;
      pc_n    = ex_pc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= TS_IDLE;
      young_q <= '0;
      ctx_q   <= 1'b0;
      vld_q   <= 1'b0;
      seq_q   <= '0;
      pc_q    <= '0;
    end else begin
      st_q    <= st_n;
      young_q <= young_n;
      ctx_q   <= ctx_n;
      vld_q   <= vld_n;
      seq_q   <= seq_n;
      pc_q    <= pc_n;
    end
  end

  assign state_o     = st_q;
  assign trap_wait_o = tmr_busy && !tmr_fire;
  assign sq_vld_o    = vld_q;
  assign sq_seq_o    = seq_q;
  assign sq_pc_o     = pc_q;
endmodule

// File: rtl/thread_squash_ctrl.sv
module thread_squash_ctrl
  import tsq_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int SEQ_W       = 16,
  parameter int PC_W        = 32,
  parameter int LAT_W       = 8,
  localparam int CNT_W      = $clog2(NUM_THREADS + 1)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [LAT_W-1:0]                    trap_lat_i,
  input  logic [NUM_THREADS-1:0]              ex_squash_i,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   ex_seq_i,
  input  logic [NUM_THREADS-1:0]              ex_incl_i,
  input  logic [NUM_THREADS-1:0][PC_W-1:0]    ex_pc_i,
  input  logic [NUM_THREADS-1:0]              ins_valid_i,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   ins_seq_i,
  input  logic [NUM_THREADS-1:0]              fetch_fault_i,
  input  logic [NUM_THREADS-1:0]              fetch_clear_i,
  input  logic [NUM_THREADS-1:0]              trap_req_i,
  input  logic [NUM_THREADS-1:0]              ctx_squash_i,
  input  logic [NUM_THREADS-1:0]              rob_done_i,
  input  logic [NUM_THREADS-1:0]              rob_empty_i,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   rob_head_seq_i,
  input  logic [NUM_THREADS-1:0][PC_W-1:0]    restart_pc_i,
  output logic [NUM_THREADS-1:0]              sq_valid_o,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   sq_seq_o,
  output logic [NUM_THREADS-1:0][PC_W-1:0]    sq_pc_o,
  output logic [NUM_THREADS-1:0]              sq_rob_o,
  output logic [NUM_THREADS-1:0]              fault_pend_o,
  output logic [CNT_W-1:0]                    squash_cnt_o,
  output logic                                stall_o
);
  tstate_e                      st_arr [NUM_THREADS];
  logic [NUM_THREADS-1:0][2:0]  st_vec;
  logic [NUM_THREADS-1:0]       trap_wait;
  logic [CNT_W-1:0]             cnt;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    tsq_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) u_thr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .stall_i     (stall_o),
      .lat_i       (trap_lat_i),
      .ex_vld_i    (ex_squash_i[g]),
      .ex_seq_i    (ex_seq_i[g]),
      .ex_incl_i   (ex_incl_i[g]),
      .ex_pc_i     (ex_pc_i[g]),
      .ins_vld_i   (ins_valid_i[g]),
      .ins_seq_i   (ins_seq_i[g]),
      .fault_i     (fetch_fault_i[g]),
      .clear_i     (fetch_clear_i[g]),
      .trap_req_i  (trap_req_i[g]),
      .ctx_req_i   (ctx_squash_i[g]),
      .rob_done_i  (rob_done_i[g]),
      .rob_empty_i (rob_empty_i[g]),
      .head_seq_i  (rob_head_seq_i[g]),
      .restart_pc_i(restart_pc_i[g]),
      .state_o     (st_arr[g]),
      .trap_wait_o (trap_wait[g]),
      .sq_vld_o    (sq_valid_o[g]),
      .sq_seq_o    (sq_seq_o[g]),
      .sq_pc_o     (sq_pc_o[g])
    );
    assign st_vec[g]       = st_arr[g];
    assign sq_rob_o[g]     = (st_arr[g] == TS_SQ);
    assign fault_pend_o[g] = (st_arr[g] == TS_FTRAP);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_THREADS; i++) cnt = cnt + CNT_W'(sq_rob_o[i]);
  end

  assign squash_cnt_o = cnt;
  assign stall_o      = (cnt == CNT_W'(NUM_THREADS));
endmodule

// File: rtl/thread_squash_ctrl_chk.sv
module thread_squash_ctrl_chk #(
  parameter int NUM_THREADS = 2,
  localparam int CNT_W      = $clog2(NUM_THREADS + 1)
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [NUM_THREADS-1:0][2:0]        st_vec_i,
  input logic [NUM_THREADS-1:0]             trap_wait_i,
  input logic [NUM_THREADS-1:0]             rob_done_i,
  input logic [NUM_THREADS-1:0]             fetch_fault_i,
  input logic [NUM_THREADS-1:0]             trap_req_i,
  input logic [NUM_THREADS-1:0]             sq_valid_i,
  input logic [NUM_THREADS-1:0]             sq_rob_i,
  input logic [CNT_W-1:0]                   squash_cnt_i,
  input logic                               stall_i
);
  localparam logic [2:0] S_SQ    = 3'd2;
  localparam logic [2:0] S_TRAP  = 3'd3;
  localparam logic [2:0] S_FTRAP = 3'd4;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
    a_r3_pulse_in_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sq_valid_i[t] |-> sq_rob_i[t]);
    a_r4_squash_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_vec_i[t] == S_SQ && !rob_done_i[t] && !fetch_fault_i[t] && !trap_req_i[t])
      |=> st_vec_i[t] == S_SQ);
    a_r5_trap_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_wait_i[t] |=> st_vec_i[t] == S_TRAP);
    a_r8_fault_blocked_by_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_vec_i[t] == S_TRAP && fetch_fault_i[t]) |=> st_vec_i[t] != S_FTRAP);
  end

  a_r9_stall_all_squashing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (&sq_rob_i));
  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_cnt_i <= CNT_W'(NUM_THREADS));
endmodule

bind thread_squash_ctrl thread_squash_ctrl_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .st_vec_i     (st_vec),
  .trap_wait_i  (trap_wait),
  .rob_done_i   (rob_done_i),
  .fetch_fault_i(fetch_fault_i),
  .trap_req_i   (trap_req_i),
  .sq_valid_i   (sq_valid_o),
  .sq_rob_i     (sq_rob_o),
  .squash_cnt_i (squash_cnt_o),
  .stall_i      (stall_o)
);

// File: tb/thread_squash_ctrl_bench.sv
module thread_squash_ctrl_bench;
  localparam int NT = 2;
  localparam int SW = 16;
  localparam int PW = 32;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [LW-1:0]          trap_lat;
  logic [NT-1:0]          ex_squash, ex_incl, ins_valid, fetch_fault, fetch_clear;
  logic [NT-1:0]          trap_req, ctx_squash, rob_done, rob_empty;
  logic [NT-1:0][SW-1:0]  ex_seq, ins_seq, rob_head_seq;
  logic [NT-1:0][PW-1:0]  ex_pc, restart_pc;
  logic [NT-1:0]          sq_valid, sq_rob, fault_pend;
  logic [NT-1:0][SW-1:0]  sq_seq;
  logic [NT-1:0][PW-1:0]  sq_pc;
  logic [1:0]             squash_cnt;
  logic                   stall;

  thread_squash_ctrl #(.NUM_THREADS(NT), .SEQ_W(SW), .PC_W(PW), .LAT_W(LW)) u_thread_squash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .trap_lat_i(trap_lat),
    .ex_squash_i(ex_squash), .ex_seq_i(ex_seq), .ex_incl_i(ex_incl), .ex_pc_i(ex_pc),
    .ins_valid_i(ins_valid), .ins_seq_i(ins_seq),
    .fetch_fault_i(fetch_fault), .fetch_clear_i(fetch_clear),
    .trap_req_i(trap_req), .ctx_squash_i(ctx_squash),
    .rob_done_i(rob_done), .rob_empty_i(rob_empty), .rob_head_seq_i(rob_head_seq),
    .restart_pc_i(restart_pc),
    .sq_valid_o(sq_valid), .sq_seq_o(sq_seq), .sq_pc_o(sq_pc), .sq_rob_o(sq_rob),
    .fault_pend_o(fault_pend), .squash_cnt_o(squash_cnt), .stall_o(stall)
  );

  typedef struct {
    int          tid;
    logic [15:0] seq;
    logic [31:0] pc;
    string       req;
  } exp_t;

  exp_t sb[$];
  exp_t e;
  int   n_chk = 0;
  int   n_err = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int tid, logic [15:0] seq, logic [31:0] pc, string req);
    sb.push_back('{tid, seq, pc, req});
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr();
    ex_squash = '0; ex_incl = '0; ins_valid = '0; fetch_fault = '0;
    fetch_clear = '0; trap_req = '0; ctx_squash = '0; rob_done = '0;
  endtask

  task automatic ex(int t, logic [15:0] s, logic inc, logic [31:0] pc);
    ex_squash[t] = 1'b1; ex_seq[t] = s; ex_incl[t] = inc; ex_pc[t] = pc;
  endtask

  // scoreboard monitor: every command pulse must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < NT; t++) begin
        if (sq_valid[t]) begin
          n_chk++;
          if (sb.size() == 0) begin
            n_err++;
            $display("FAIL R1 unexpected command thread=%0d seq=%0h actual=pulse expected=none",
                     t, sq_seq[t]);
          end else begin
            e = sb.pop_front();
            if (e.tid != t || sq_seq[t] !== e.seq || sq_pc[t] !== e.pc) begin
              n_err++;
              $display("FAIL %s actual=t%0d/%0h/%0h expected=t%0d/%0h/%0h",
                       e.req, t, sq_seq[t], sq_pc[t], e.tid, e.seq, e.pc);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    clr();
    trap_lat = '0; ex_seq = '0; ins_seq = '0; ex_pc = '0;
    rob_empty = '1; rob_head_seq = '0; restart_pc = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk("R10 reset rob", 32'(sq_rob), 0);
    chk("R10 reset cnt", 32'(squash_cnt), 0);
    chk("R10 reset stall", 32'(stall), 0);
    chk("R10 reset fault", 32'(fault_pend), 0);

    // R10 insertion records youngest
    ins_valid = 2'b11; ins_seq[0] = 16'd10; ins_seq[1] = 16'd20;
    tick(); clr();

    // R3 accepted squash
    ex(0, 16'd8, 1'b0, 32'h100); push(0, 16'd8, 32'h100, "R3");
    tick(); clr();
    chk("R3 rob flag", 32'(sq_rob[0]), 1);
    chk("R3 count", 32'(squash_cnt), 1);

    // R4 done squashing
    rob_done[0] = 1'b1;
    tick(); clr();
    chk("R4 rob flag clear", 32'(sq_rob[0]), 0);
    chk("R4 count", 32'(squash_cnt), 0);

    // R1 younger than recorded youngest (8): rejected
    ex(0, 16'd9, 1'b0, 32'h1ff);
    tick(); clr();
    chk("R1 age reject", 32'(sq_rob[0]), 0);

    // R2 include-self
    ex(0, 16'd8, 1'b1, 32'h104); push(0, 16'd7, 32'h104, "R2");
    tick(); clr();
    chk("R2 rob flag", 32'(sq_rob[0]), 1);
    rob_done[0] = 1'b1; tick(); clr();

    // R5 trap with latency 3 on thread 1
    trap_lat = 8'd3; rob_empty[1] = 1'b0; rob_head_seq[1] = 16'd15; restart_pc[1] = 32'h2000;
    trap_req[1] = 1'b1; push(1, 16'd14, 32'h2000, "R5");
    tick(); clr();
    for (int k = 1; k <= 3; k++) begin
      if (k == 1) ex(1, 16'd5, 1'b0, 32'h2fff); // R1 ignored in trap-wait
      tick(); clr();
      chk("R5 no early trap pulse", 32'(sq_valid[1]), 0);
    end
    tick(); clr();
    chk("R5 trap pulse at L+1", 32'(sq_valid[1]), 1);
    chk("R5 squashing", 32'(sq_rob[1]), 1);
    rob_done[1] = 1'b1; tick(); clr();

    // R7 youngest reset to zero
    ex(1, 16'd1, 1'b0, 32'h2eee);
    tick(); clr();
    chk("R7 youngest zero rejects 1", 32'(sq_rob[1]), 0);
    ex(1, 16'd0, 1'b0, 32'h2100); push(1, 16'd0, 32'h2100, "R7");
    tick(); clr();
    rob_done[1] = 1'b1; tick(); clr();

    // R7 context squash with empty buffer
    rob_empty[0] = 1'b1; restart_pc[0] = 32'h1000;
    ctx_squash[0] = 1'b1; push(0, 16'd0, 32'h1000, "R7");
    tick(); clr();
    chk("R7 ctx squashing", 32'(sq_rob[0]), 1);
    rob_done[0] = 1'b1; tick(); clr();

    // R6 trap before deferred context squash
    trap_lat = 8'd2; rob_empty[0] = 1'b0; rob_head_seq[0] = 16'd30; restart_pc[0] = 32'h1100;
    trap_req[0] = 1'b1; push(0, 16'd29, 32'h1100, "R6");
    tick(); clr();
    ctx_squash[0] = 1'b1;
    tick(); clr();
    chk("R6 ctx held", 32'(sq_valid[0]), 0);
    tick(); clr();
    chk("R6 ctx held", 32'(sq_valid[0]), 0);
    tick(); clr();
    chk("R6 trap pulse first", 32'(sq_valid[0]), 1);
    rob_head_seq[0] = 16'd40; restart_pc[0] = 32'h1200; push(0, 16'd39, 32'h1200, "R6");
    tick(); clr();
    chk("R6 ctx pulse next", 32'(sq_valid[0]), 1);
    rob_done[0] = 1'b1; tick(); clr();
    chk("R4 back to running", 32'(sq_rob[0]), 0);

    // R8 fetch fault and clear
    fetch_fault[0] = 1'b1; tick(); clr();
    chk("R8 fault pending", 32'(fault_pend[0]), 1);
    fetch_clear[0] = 1'b1; tick(); clr();
    chk("R8 fault cleared", 32'(fault_pend[0]), 0);

    // R8 fault ignored during trap-wait
    rob_empty[1] = 1'b1; restart_pc[1] = 32'h2000;
    trap_req[1] = 1'b1; push(1, 16'd0, 32'h2000, "R8");
    tick(); clr();
    fetch_fault[1] = 1'b1; tick(); clr();
    chk("R8 fault blocked by trap", 32'(fault_pend[1]), 0);
    tick(); clr();
    tick(); clr();
    chk("R8 trap still fires", 32'(sq_valid[1]), 1);
    rob_done[1] = 1'b1; tick(); clr();

    // R9 all threads squashing
    ins_valid = 2'b11; ins_seq[0] = 16'd100; ins_seq[1] = 16'd200;
    tick(); clr();
    ex(0, 16'd50, 1'b0, 32'h300); push(0, 16'd50, 32'h300, "R9");
    ex(1, 16'd150, 1'b0, 32'h400); push(1, 16'd150, 32'h400, "R9");
    tick(); clr();
    chk("R9 count two", 32'(squash_cnt), 2);
    chk("R9 stall", 32'(stall), 1);
    ins_valid[0] = 1'b1; ins_seq[0] = 16'd300;
    tick(); clr();
    rob_done[1] = 1'b1; tick(); clr();
    chk("R4 count one", 32'(squash_cnt), 1);
    chk("R9 stall off", 32'(stall), 0);
    rob_done[0] = 1'b1; tick(); clr();
    ex(0, 16'd60, 1'b0, 32'h5ff);
    tick(); clr();
    chk("R9 insertion dropped", 32'(sq_rob[0]), 0);
    ex(0, 16'd45, 1'b0, 32'h500); push(0, 16'd45, 32'h500, "R9");
    tick(); clr();
    chk("R3 accepted below youngest", 32'(sq_rob[0]), 1);
    rob_done[0] = 1'b1; tick(); clr();
    tick();

    chk("R3 all commands seen", 32'(sb.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule